// File: doc/BRIEF.md
# Byte-Lane Interleaved Multi-String Matcher

This block looks for a set of fixed byte strings in a stream that arrives four bytes per clock. Each byte lane of the input word has its own small single-byte automaton. An automaton only ever sees every fourth byte of the stream. To make that work, each search string is split into four interleaved substrings, one for each residue of the character index modulo four. Every lane keeps its progress on all four substrings of every string. A combiner then joins lane progress across lanes and across two consecutive words. This lets an occurrence start and end at any byte offset, including across word boundaries.

Strings are loaded one byte at a time through a table port, together with a length per string. A length of zero disables that string. Preparing the string contents is left to software. The stream can pause: while the valid input is low, all automata keep their progress. On each accepted word, the block raises a one-cycle flag per string that completed in that word, along with the lane that holds the final byte of the occurrence.

Top module: `parallel_string_matcher`

## Requirements
- R1: While reset is asserted and right after it, every bit of matchFlag and matchLane is 0.
- R2: String s gets its character k (k = 0 is the first character) from a cycle with ldChar high, ldStr = s, ldPos = k and ldByte = the character. It gets its length from a cycle with ldLen high, ldStr = s and ldLength = the length (1 to 32). Reset sets every length to 0, so no string can match until lengths are loaded again.
- R3: Within a word, byte lane i is inData[8i+7:8i], and lane 0 is the earliest byte in stream order.
- R4: Suppose an occurrence of string s lies entirely inside a word accepted at rising edge t. Then matchFlag[s] is 1 and matchLane[2s+1:2s] holds the lane of its last byte during the cycle after edge t+1.
- R5: An occurrence that starts at any of the four lane offsets and spans several words is reported in the cycle after the edge that follows the word holding its last byte.
- R6: Cycles with inValid low do not advance or disturb any automaton. Bytes on either side of such a gap are treated as adjacent in the stream. No flag is raised for a word that was not valid.
- R7: Flags are single-cycle pulses, one per accepted word. When a flag is 0, the lane field for that string is 0.
- R8: If string s completes at more than one lane within the same word, the lowest of those lanes is reported.
- R9: Strings are matched independently, and several flags may be high in the same cycle.
- R10: Self-overlapping occurrences (for example a string of repeated bytes) are each recognised.
- R11: A string of the full 32-byte length is detected at every start offset.
- R12: A string whose length is 0 never raises its flag, whatever its loaded characters.
- R13: Reset discards all partial progress, so bytes seen before reset never contribute to a match after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | inData carries a stream word this cycle |
| inData | input | 32 | Four stream bytes, lane 0 in bits 7:0 |
| ldChar | input | 1 | Write one pattern character |
| ldLen | input | 1 | Write one pattern length |
| ldStr | input | 3 | String index for a table write |
| ldPos | input | 5 | Character position for a character write |
| ldByte | input | 8 | Character value for a character write |
| ldLength | input | 6 | Length value for a length write, 0 to 32 |
| matchFlag | output | 8 | Bit s pulses when string s completed in the word |
| matchLane | output | 16 | Bits 2s+1:2s give the last-byte lane for string s |

## Verification
The assertions assume that table writes happen only while no match is in progress, that ldLength never exceeds 32, and that inValid stays low during reset. Under those conditions, state advances only on valid words and every reported flag traces back to a non-empty string. The bench respects these limits. It loads all strings during idle cycles before streaming, writes only lengths from 0 to 32, and holds inValid low around every reset. Its expected flags come from a byte-history model that compares each candidate end position against the loaded strings.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int DEF_LANES  = 4;
  localparam int DEF_NSTR   = 8;
  localparam int DEF_MAXLEN = 32;

  // strobes issued by control to the datapath each cycle
  typedef struct packed {
    logic step;    // advance lane automata with the current word
    logic wrChar;  // write one pattern character
    logic wrLen;   // write one pattern length
    logic emit;    // the previous cycle advanced the automata: publish result
  } strobes_t;
endpackage

// File: rtl/sm_ctrl.sv
module sm_ctrl (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              ldChar,
  input  logic              ldLen,
  output sm_pkg::strobes_t  strobes
);
  logic emitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) emitQ <= 1'b0;
    else       emitQ <= inValid;
  end

  always_comb begin
    strobes.step   = inValid;
    strobes.wrChar = ldChar;
    strobes.wrLen  = ldLen;
    strobes.emit   = emitQ;
  end
endmodule

// File: rtl/sm_lane.sv
// One single-byte automaton: sees one byte lane, tracks for every string the
// four interleaved substrings (character index modulo LANES) as shift-and
// progress vectors.
module sm_lane #(
  parameter int NSTR   = 8,
  parameter int MAXLEN = 32,
  parameter int LANES  = 4,
  parameter int LW     = 6
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                step,
  input  logic [7:0]                          laneByte,
  input  logic [NSTR-1:0][MAXLEN-1:0][7:0]    patChar,
  input  logic [NSTR-1:0][LW-1:0]             patLen,
  output logic [NSTR-1:0][LANES-1:0]          doneNow,
  output logic [NSTR-1:0][LANES-1:0]          donePrev
);
  localparam int SUB  = MAXLEN / LANES;
  localparam int LIW  = $clog2(LANES);
  localparam int SUBW = (SUB > 1) ? $clog2(SUB) : 1;

  logic [NSTR-1:0][LANES-1:0][SUB-1:0] st, stNxt;

  for (genvar s = 0; s < NSTR; s++) begin : g_str
    for (genvar ph = 0; ph < LANES; ph++) begin : g_ph
      logic            dn;
      logic [SUBW-1:0] mIdx;
      int              n;

      assign stNxt[s][ph][0] = (laneByte == patChar[s][ph]);
      for (genvar j = 1; j < SUB; j++) begin : g_pos
        assign stNxt[s][ph][j] = st[s][ph][j-1] & (laneByte == patChar[s][ph + LANES*j]);

        // R10: a deeper progress bit only appears on top of the one below it
        a_r10_progress: assert property (@(posedge clk) disable iff (!rstN)
          ($past(step) && st[s][ph][j]) |-> $past(st[s][ph][j-1]));
      end

      // last character of this substring sits at progress bit m-1
      always_comb begin
        n    = int'(patLen[s]);
        mIdx = '0;
        dn   = 1'b0;
        if (n > ph) begin
          mIdx = SUBW'(((n - ph + LANES - 1) >> LIW) - 1);
          dn   = st[s][ph][mIdx];
        end
      end
      assign doneNow[s][ph] = dn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= '0;
      donePrev <= '0;
    end else if (step) begin
      st       <= stNxt;
      donePrev <= doneNow;
    end
  end

  // R6: nothing moves while no word is accepted
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> ($stable(st) && $stable(donePrev)));
endmodule

// File: rtl/sm_datapath.sv
module sm_datapath #(
  parameter int NSTR   = 8,
  parameter int MAXLEN = 32,
  parameter int LANES  = 4,
  parameter int SW     = 3,
  parameter int PW     = 5,
  parameter int LW     = 6,
  parameter int LIW    = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  sm_pkg::strobes_t              strobes,
  input  logic [LANES*8-1:0]            inData,
  input  logic [SW-1:0]                 ldStr,
  input  logic [PW-1:0]                 ldPos,
  input  logic [7:0]                    ldByte,
  input  logic [LW-1:0]                 ldLength,
  output logic [NSTR-1:0]               matchFlag,
  output logic [NSTR-1:0][LIW-1:0]      matchLane
);
  logic [NSTR-1:0][MAXLEN-1:0][7:0] patChar;
  logic [NSTR-1:0][LW-1:0]          patLen;

  // pattern table: characters keep no reset value, lengths reset to disabled
  always_ff @(posedge clk) begin
    if (strobes.wrChar) patChar[ldStr][ldPos] <= ldByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              patLen <= '0;
    else if (strobes.wrLen) patLen[ldStr] <= ldLength;
  end

  // per-lane automata
  logic [LANES-1:0][NSTR-1:0][LANES-1:0] laneNow, lanePrev;

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    sm_lane #(.NSTR(NSTR), .MAXLEN(MAXLEN), .LANES(LANES), .LW(LW)) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .step     (strobes.step),
      .laneByte (inData[8*L +: 8]),
      .patChar  (patChar),
      .patLen   (patLen),
      .doneNow  (laneNow[L]),
      .donePrev (lanePrev[L])
    );
  end

  // combiner: for each string and each candidate end lane, derive the start
  // alignment, then AND the substring completions from every lane taken from
  // the current or the previous word
  logic [NSTR-1:0]           flagNxt;
  logic [NSTR-1:0][LIW-1:0]  laneNxt;

  for (genvar s = 0; s < NSTR; s++) begin : g_comb
    logic [LANES-1:0] hitE;

    for (genvar e = 0; e < LANES; e++) begin : g_end
      logic [LANES-1:0] term;

      for (genvar L = 0; L < LANES; L++) begin : g_src
        logic           tv;
        logic [LIW-1:0] aV, phV;
        int             n, kLast, offL, offE;

        always_comb begin
          n     = int'(patLen[s]);
          aV    = LIW'(e + 1 - n);
          phV   = LIW'(L) - aV;
          tv    = 1'b1;
          kLast = 0;
          offL  = 0;
          offE  = 0;
          if (n > int'(phV)) begin
            kLast = int'(phV) + (((n - 1 - int'(phV)) >> LIW) << LIW);
            offL  = (int'(aV) + kLast) >> LIW;
            offE  = (int'(aV) + n - 1) >> LIW;
            tv    = (offE != offL) ? lanePrev[L][s][phV] : laneNow[L][s][phV];
          end
        end
        assign term[L] = tv;
      end

      assign hitE[e] = (patLen[s] != '0) && (&term);
    end

    // lowest end lane wins
    always_comb begin
      flagNxt[s] = 1'b0;
      laneNxt[s] = '0;
      for (int e = LANES - 1; e >= 0; e--) begin
        if (hitE[e]) begin
          flagNxt[s] = 1'b1;
          laneNxt[s] = LIW'(e);
        end
      end
    end

    // R12: a disabled string never reports
    a_r12_zero_len: assert property (@(posedge clk) disable iff (!rstN)
      matchFlag[s] |-> ($past(patLen[s]) != '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchFlag <= '0;
      matchLane <= '0;
    end else if (strobes.emit) begin
      matchFlag <= flagNxt;
      matchLane <= laneNxt;
    end else begin
      matchFlag <= '0;
      matchLane <= '0;
    end
  end
endmodule

// File: rtl/parallel_string_matcher.sv
module parallel_string_matcher #(
  parameter  int NSTR   = sm_pkg::DEF_NSTR,
  parameter  int MAXLEN = sm_pkg::DEF_MAXLEN,
  parameter  int LANES  = sm_pkg::DEF_LANES,
  localparam int SW     = $clog2(NSTR),
  localparam int PW     = $clog2(MAXLEN),
  localparam int LW     = $clog2(MAXLEN + 1),
  localparam int LIW    = $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [LANES*8-1:0]    inData,
  input  logic                  ldChar,
  input  logic                  ldLen,
  input  logic [SW-1:0]         ldStr,
  input  logic [PW-1:0]         ldPos,
  input  logic [7:0]            ldByte,
  input  logic [LW-1:0]         ldLength,
  output logic [NSTR-1:0]       matchFlag,
  output logic [NSTR*LIW-1:0]   matchLane
);
  sm_pkg::strobes_t        strobes;
  logic [NSTR-1:0][LIW-1:0] laneQ;

  sm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .ldChar  (ldChar),
    .ldLen   (ldLen),
    .strobes (strobes)
  );

  sm_datapath #(.NSTR(NSTR), .MAXLEN(MAXLEN), .LANES(LANES),
                .SW(SW), .PW(PW), .LW(LW), .LIW(LIW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inData    (inData),
    .ldStr     (ldStr),
    .ldPos     (ldPos),
    .ldByte    (ldByte),
    .ldLength  (ldLength),
    .matchFlag (matchFlag),
    .matchLane (laneQ)
  );

  assign matchLane = laneQ;

  // R6: a flag always traces back to a word accepted two edges earlier
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (|matchFlag) |-> $past(inValid, 2));
endmodule

// File: tb/parallel_string_matcher_tb_top.sv
module parallel_string_matcher_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        ldChar = 1'b0, ldLen = 1'b0;
  logic [2:0]  ldStr = '0;
  logic [4:0]  ldPos = '0;
  logic [7:0]  ldByte = '0;
  logic [5:0]  ldLength = '0;
  logic [7:0]  matchFlag;
  logic [15:0] matchLane;

  always #4 clk = ~clk;  // 125 MHz

  parallel_string_matcher dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .ldChar(ldChar), .ldLen(ldLen), .ldStr(ldStr), .ldPos(ldPos),
    .ldByte(ldByte), .ldLength(ldLength),
    .matchFlag(matchFlag), .matchLane(matchLane)
  );

  int          nChecks = 0, nFail = 0;
  string       curReq = "R1";
  logic [7:0]  hist [0:4095];
  int          histN = 0;
  logic [7:0]  bPat [8][32];
  int          bLen [8];
  logic [7:0]  expFlagA = '0, expFlagB = '0;
  logic [15:0] expLaneA = '0, expLaneB = '0;

  // reference: append the word, then test every end lane against history
  task automatic modelWord(input logic [31:0] w, output logic [7:0] f, output logic [15:0] ln);
    f = '0; ln = '0;
    for (int l = 0; l < 4; l++) hist[histN + l] = w[8*l +: 8];
    histN += 4;
    for (int s = 0; s < 8; s++) begin
      for (int e = 0; e < 4; e++) begin
        int p = histN - 4 + e;
        int n = bLen[s];
        bit ok = (n > 0) && (p + 1 >= n);
        if (ok) for (int k = 0; k < n; k++) if (hist[p - n + 1 + k] != bPat[s][k]) ok = 0;
        if (ok && !f[s]) begin f[s] = 1'b1; ln[2*s +: 2] = 2'(e); end
      end
    end
  endtask

  task automatic checkOut();
    nChecks++;
    if (matchFlag !== expFlagA || matchLane !== expLaneA) begin
      nFail++;
      $display("FAIL %s: flags=%h lanes=%h expected flags=%h lanes=%h",
               curReq, matchFlag, matchLane, expFlagA, expLaneA);
    end
  endtask

  task automatic cycle(input bit v, input logic [31:0] d, input bit wc, input bit wl,
                       input int s, input int pos, input logic [7:0] b, input int len);
    @(negedge clk);
    checkOut();
    expFlagA = expFlagB; expLaneA = expLaneB;
    if (v) modelWord(d, expFlagB, expLaneB);
    else begin expFlagB = '0; expLaneB = '0; end
    inValid = v; inData = d; ldChar = wc; ldLen = wl;
    ldStr = 3'(s); ldPos = 5'(pos); ldByte = b; ldLength = 6'(len);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cycle(0, '0, 0, 0, 0, 0, '0, 0);
  endtask

  task automatic setLen(input int s, input int len);
    cycle(0, '0, 0, 1, s, 0, '0, len);
    bLen[s] = len;
  endtask

  task automatic loadStr(input int s, input string str);
    for (int k = 0; k < str.len(); k++) begin
      cycle(0, '0, 1, 0, s, k, str[k], 0);
      bPat[s][k] = str[k];
    end
    setLen(s, str.len());
  endtask

  task automatic loadAll();
    loadStr(0, "abc");
    loadStr(1, "hello world");
    loadStr(2, "0123456789ABCDEFGHIJKLMNOPQRSTUV");
    loadStr(3, "aaa");
    loadStr(4, "z");
    loadStr(5, "qrs");
    setLen(5, 0);
    loadStr(6, "xyzxy");
    loadStr(7, "cab");
    idle(2);
  endtask

  // stream a string after 'off' filler bytes, padded to whole words
  task automatic sendStream(input string str, input int off, input int gap);
    logic [7:0] bq[$];
    for (int i = 0; i < off; i++) bq.push_back(8'h2e);
    for (int i = 0; i < str.len(); i++) bq.push_back(str[i]);
    while (bq.size() % 4 != 0) bq.push_back(8'h2e);
    for (int w = 0; w < bq.size() / 4; w++) begin
      cycle(1, {bq[4*w+3], bq[4*w+2], bq[4*w+1], bq[4*w]}, 0, 0, 0, 0, '0, 0);
      if (gap > 0) idle(gap);
    end
    idle(2);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; ldChar = 1'b0; ldLen = 1'b0;
    histN = 0;
    for (int s = 0; s < 8; s++) bLen[s] = 0;
    expFlagA = '0; expFlagB = '0; expLaneA = '0; expLaneB = '0;
    repeat (2) @(negedge clk);
    curReq = "R1";
    checkOut();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_reset_state();
    curReq = "R1";
    @(negedge clk); checkOut();
    rstN = 1'b1;
    idle(3);
  endtask

  task automatic t_no_strings();
    curReq = "R2 (lengths cleared by reset)";
    bPat[0][0] = "a"; bPat[0][1] = "b"; bPat[0][2] = "c";
    sendStream("abcabc", 0, 0);
  endtask

  task automatic t_in_word();
    curReq = "R4 (R3 lane order)";
    sendStream("abc", 0, 0);
    sendStream("abc", 1, 0);
    sendStream("zz.z", 0, 0);
  endtask

  task automatic t_span();
    curReq = "R5";
    for (int off = 0; off < 4; off++) sendStream("hello world", off, 0);
  endtask

  task automatic t_gap();
    curReq = "R6";
    sendStream("hello world", 2, 2);
    sendStream("xyzxy", 3, 1);
  endtask

  task automatic t_pulse();
    curReq = "R7";
    sendStream("..abc...cab.", 0, 0);
    idle(4);
  endtask

  task automatic t_overlap();
    curReq = "R8 R10";
    sendStream("aaaaaaa", 0, 0);
    sendStream("aaaaaaaaaa", 1, 0);
  endtask

  task automatic t_multi();
    curReq = "R9";
    sendStream("zabc", 0, 0);
    sendStream("xyzxyzxyab", 0, 0);
  endtask

  task automatic t_long();
    curReq = "R11";
    for (int off = 0; off < 4; off++) sendStream("0123456789ABCDEFGHIJKLMNOPQRSTUV", off, 0);
  endtask

  task automatic t_zero();
    curReq = "R12";
    sendStream("qrsqrs", 0, 0);
    sendStream("qrs", 1, 0);
  endtask

  task automatic t_reset_progress();
    curReq = "R13";
    sendStream("hello wo", 0, 0);
    doReset();
    curReq = "R13";
    loadAll();
    sendStream("rld", 0, 0);
    sendStream("aab", 0, 0);
  endtask

  initial begin
    for (int s = 0; s < 8; s++) begin
      bLen[s] = 0;
      for (int k = 0; k < 32; k++) bPat[s][k] = '0;
    end
    repeat (3) @(negedge clk);
    t_reset_state();
    t_no_strings();
    loadAll();
    t_in_word();
    t_span();
    t_gap();
    t_pulse();
    t_overlap();
    t_multi();
    t_long();
    t_zero();
    t_reset_progress();
    idle(2);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog (R1-R13 run): actual hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule